// File: doc/BRIEF.md
# Dual-Port Video Memory Controller

This block drives a video memory built from two 4-bit-wide dual-ported devices that sit side by side and form one byte. Each device has a slow random port, reached through a narrow address bus that carries the row, then the column, then (for a write) the data, and a fast read-only serial port. The serial port is fed from a row register that is loaded with a whole device row in one internal transfer. A synthesizable array inside the block models the devices.

Random reads and writes are issued through a request/ready handshake and take three bus cycles each. A stream is started by naming a row and a starting column. Once the stream runs, it returns one byte per cycle (one nibble from each device) without touching the address bus. When the column pointer passes the end of the row, the following row is reloaded into the row register automatically. Random accesses go on alongside a running stream. Loading a new, non-contiguous row needs the bus, and it takes priority over random work.

Top module: `dpvram_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `abus_ph` is 0 (idle), `abus` is 0, `rnd_rvalid` and `ser_valid` are 0, and `rnd_ready` is 1.
- R2: An accepted random access puts three phases on consecutive cycles, coded on `abus_ph` as 1 (row, `abus` = row), 2 (column, `abus` = column) and 3 (data, `abus` = write byte for a write, 0 for a read). Idle is coded 0 with `abus` = 0.
- R3: A random request is accepted on a clock edge where `rnd_req` and `rnd_ready` are both 1. `rnd_ready` is 1 only in the idle or data phase and only when no stream start is being requested or held. Back-to-back requests therefore complete one every three cycles.
- R4: A read raises `rnd_rvalid` during its data phase, with `rnd_rdata` holding the byte most recently written to that row and column. A write stores its byte at the end of its data phase.
- R5: A stream start uses two bus phases on consecutive cycles: 4 (row transfer, `abus` = row) and 5 (pointer set, `abus` = start column). `ser_valid` is 0 during both. On the next cycle `ser_valid` is 1 and `ser_data` is the byte at that row and column. Bits 3:0 come from device 0 and bits 7:4 from device 1.
- R6: While a stream runs, each cycle presents the next column's byte. Random reads and writes proceed at the same time and do not disturb it.
- R7: After column 255 the stream continues with column 0 of the next row, wrapping from the last row to row 0, with no bus phase and no gap in `ser_valid`.
- R8: When `ser_start` and `rnd_req` arrive in the same cycle, the start wins. `rnd_ready` stays 0 and the random request waits until the pointer-set phase has ended.
- R9: A start that arrives while a random access is in flight is held. Its row-transfer phase follows the data phase directly.
- R10: A start issued while a stream is running replaces that stream. A start that arrives during another start's transfer phases is executed immediately after that start's pointer-set phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnd_req | input | 1 | Random access request |
| rnd_we | input | 1 | 1 = write, 0 = read |
| rnd_row | input | ROW_W | Random access row |
| rnd_col | input | COL_W | Random access column |
| rnd_wdata | input | DATA_W | Write byte |
| rnd_ready | output | 1 | Random request can be accepted |
| rnd_rvalid | output | 1 | Read data valid |
| rnd_rdata | output | DATA_W | Read data |
| ser_start | input | 1 | Start a stream (one-cycle pulse) |
| ser_row | input | ROW_W | Row to stream |
| ser_ptr | input | COL_W | Starting column |
| ser_valid | output | 1 | Stream byte valid |
| ser_data | output | DATA_W | Stream byte (one nibble per device) |
| abus | output | ADDR_W | Multiplexed address/data bus |
| abus_ph | output | 3 | Current bus phase code |

## Verification
The stimulus mixes several patterns. Long runs of back-to-back writes show whether the three-cycle cadence and the order of the bus phases hold up under continuous demand. Reads of scattered addresses show whether the read returns the right byte in the right phase. A stream that starts near the end of a row shows whether the automatic reload and the wrap from the last row to the first happen without a gap. Starts that coincide with a random request, land inside a random access, interrupt a running stream or follow one another in consecutive cycles test the priority rules and the holding of a pending start. A reference model compares every output on every cycle.

// File: rtl/dpv_pkg.sv
package dpv_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ROW  = 3'd1,
    PH_COL  = 3'd2,
    PH_DATA = 3'd3,
    PH_XROW = 3'd4,
    PH_XPTR = 3'd5
  } phase_e;
endpackage

// File: rtl/dpv_seq.sv
module dpv_seq
  import dpv_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rnd_req,
  input  logic              rnd_we,
  input  logic [ROW_W-1:0]  rnd_row,
  input  logic [COL_W-1:0]  rnd_col,
  input  logic [DATA_W-1:0] rnd_wdata,
  input  logic              ser_start,
  input  logic [ROW_W-1:0]  ser_row,
  input  logic [COL_W-1:0]  ser_ptr,
  output logic              rnd_ready,
  output logic              rvalid,
  output phase_e            ph,
  output logic [ADDR_W-1:0] abus,
  output logic              wr_en,
  output logic              rd_cap,
  output logic              x_load,
  output logic              x_set,
  output logic [ROW_W-1:0]  a_row,
  output logic [COL_W-1:0]  a_col,
  output logic [DATA_W-1:0] a_wdata,
  output logic [ROW_W-1:0]  x_row,
  output logic [COL_W-1:0]  x_ptr
);
  phase_e             ph_q, ph_d;
  logic               sp_q, sp_d;
  logic               lat_we;
  logic [ROW_W-1:0]   lat_row, sp_row, xr_q, st_row;
  logic [COL_W-1:0]   lat_col, sp_ptr, xp_q, st_ptr;
  logic [DATA_W-1:0]  lat_wd;
  logic               start_now, slot_rnd, slot_x, go_x, acc;

  // arbitration: a row transfer always beats a random request
  always_comb begin
    start_now = ser_start | sp_q;
    st_row    = ser_start ? ser_row : sp_row;
    st_ptr    = ser_start ? ser_ptr : sp_ptr;
    slot_rnd  = (ph_q == PH_IDLE) || (ph_q == PH_DATA);
    slot_x    = slot_rnd || (ph_q == PH_XPTR);
    rnd_ready = slot_rnd & ~start_now;
    go_x      = slot_x & start_now;
    acc       = rnd_req & rnd_ready;
    sp_d      = go_x ? 1'b0 : (ser_start ? 1'b1 : sp_q);
  end

  always_comb begin
    ph_d = ph_q;
    if (go_x)      ph_d = PH_XROW;
    else if (acc)  ph_d = PH_ROW;
    else begin
      case (ph_q)
        PH_ROW:  ph_d = PH_COL;
        PH_COL:  ph_d = PH_DATA;
        PH_XROW: ph_d = PH_XPTR;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      sp_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      lat_we  <= rnd_we;
      lat_row <= rnd_row;
      lat_col <= rnd_col;
      lat_wd  <= rnd_wdata;
    end
    if (ser_start) begin
      sp_row <= ser_row;
      sp_ptr <= ser_ptr;
    end
    if (go_x) begin
      xr_q <= st_row;
      xp_q <= st_ptr;
    end
  end

  always_comb begin
    case (ph_q)
      PH_ROW:  abus = ADDR_W'(lat_row);
      PH_COL:  abus = ADDR_W'(lat_col);
      PH_DATA: abus = lat_we ? ADDR_W'(lat_wd) : '0;
      PH_XROW: abus = ADDR_W'(xr_q);
      PH_XPTR: abus = ADDR_W'(xp_q);
      default: abus = '0;
    endcase
  end

  assign ph      = ph_q;
  assign wr_en   = (ph_q == PH_DATA) & lat_we;
  assign rvalid  = (ph_q == PH_DATA) & ~lat_we;
  assign rd_cap  = (ph_q == PH_COL) & ~lat_we;
  assign x_load  = (ph_q == PH_XROW);
  assign x_set   = (ph_q == PH_XPTR);
  assign a_row   = lat_row;
  assign a_col   = lat_col;
  assign a_wdata = lat_wd;
  assign x_row   = xr_q;
  assign x_ptr   = xp_q;
endmodule

// File: rtl/dpv_array.sv
module dpv_array #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                                 clk,
  input  logic                                 wr_en,
  input  logic [ROW_W-1:0]                     wr_row,
  input  logic [COL_W-1:0]                     wr_col,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic                                 rd_cap,
  input  logic [ROW_W-1:0]                     rd_row,
  input  logic [COL_W-1:0]                     rd_col,
  output logic [DATA_W-1:0]                    rd_data,
  input  logic [ROW_W-1:0]                     line_row,
  output logic [(DATA_W*(1<<COL_W))-1:0]       line
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int LINE_W = DATA_W * (1 << COL_W);

  logic [LINE_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row][int'(wr_col)*DATA_W +: DATA_W] <= wr_data;
    if (rd_cap) rd_q <= mem[rd_row][int'(rd_col)*DATA_W +: DATA_W];
  end

  assign rd_data = rd_q;
  assign line    = mem[line_row];
endmodule

// File: rtl/dpv_serial.sv
module dpv_serial #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 8,
  parameter int NIB_W  = 4,
  parameter int LANES  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load_en,
  input  logic [ROW_W-1:0]                       load_row,
  input  logic                                   set_en,
  input  logic [COL_W-1:0]                       set_ptr,
  input  logic [(NIB_W*LANES*(1<<COL_W))-1:0]    line_in,
  output logic [ROW_W-1:0]                       next_row,
  output logic                                   ser_valid,
  output logic [NIB_W*LANES-1:0]                 ser_data
);
  localparam int DATA_W = NIB_W * LANES;
  localparam int LINE_W = DATA_W * (1 << COL_W);
  localparam logic [COL_W-1:0] LAST = '1;

  logic              act_q, act_d;
  logic [COL_W-1:0]  ptr_q, ptr_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [LINE_W-1:0] buf_q;
  logic              buf_en;
  logic              wrap;

  always_comb begin
    act_d  = act_q;
    ptr_d  = ptr_q;
    row_d  = row_q;
    buf_en = 1'b0;
    wrap   = act_q && (ptr_q == LAST);
    if (load_en) begin
      act_d  = 1'b0;
      row_d  = load_row;
      buf_en = 1'b1;
    end else if (set_en) begin
      act_d = 1'b1;
      ptr_d = set_ptr;
    end else if (wrap) begin
      ptr_d  = '0;
      row_d  = next_row;
      buf_en = 1'b1;
    end else if (act_q) begin
      ptr_d = ptr_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ptr_q <= '0;
      row_q <= '0;
    end else begin
      act_q <= act_d;
      ptr_q <= ptr_d;
      row_q <= row_d;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_en) buf_q <= line_in;
  end

  assign next_row  = row_q + ROW_W'(1);
  assign ser_valid = act_q & ~load_en & ~set_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ser_data[l*NIB_W +: NIB_W] = buf_q[int'(ptr_q)*DATA_W + l*NIB_W +: NIB_W];
  end
endmodule

// File: rtl/dpvram_ctrl.sv
module dpvram_ctrl
  import dpv_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 8,
  parameter int NIB_W  = 4,
  parameter int LANES  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rnd_req,
  input  logic                    rnd_we,
  input  logic [ROW_W-1:0]        rnd_row,
  input  logic [COL_W-1:0]        rnd_col,
  input  logic [NIB_W*LANES-1:0]  rnd_wdata,
  output logic                    rnd_ready,
  output logic                    rnd_rvalid,
  output logic [NIB_W*LANES-1:0]  rnd_rdata,
  input  logic                    ser_start,
  input  logic [ROW_W-1:0]        ser_row,
  input  logic [COL_W-1:0]        ser_ptr,
  output logic                    ser_valid,
  output logic [NIB_W*LANES-1:0]  ser_data,
  output logic [ADDR_W-1:0]       abus,
  output logic [2:0]              abus_ph
);
  localparam int DATA_W = NIB_W * LANES;
  localparam int LINE_W = DATA_W * (1 << COL_W);

  logic [1:0]        rst_sync;
  logic              rst_ni;
  phase_e            ph;
  logic              wr_en, rd_cap, x_load, x_set;
  logic [ROW_W-1:0]  a_row, x_row, next_row, line_row;
  logic [COL_W-1:0]  a_col, x_ptr;
  logic [DATA_W-1:0] a_wdata;
  logic [LINE_W-1:0] line;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  dpv_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_ni),
    .rnd_req(rnd_req), .rnd_we(rnd_we), .rnd_row(rnd_row), .rnd_col(rnd_col),
    .rnd_wdata(rnd_wdata), .ser_start(ser_start), .ser_row(ser_row), .ser_ptr(ser_ptr),
    .rnd_ready(rnd_ready), .rvalid(rnd_rvalid), .ph(ph), .abus(abus),
    .wr_en(wr_en), .rd_cap(rd_cap), .x_load(x_load), .x_set(x_set),
    .a_row(a_row), .a_col(a_col), .a_wdata(a_wdata), .x_row(x_row), .x_ptr(x_ptr)
  );

  assign line_row = x_load ? x_row : next_row;

  dpv_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_row(a_row), .wr_col(a_col), .wr_data(a_wdata),
    .rd_cap(rd_cap), .rd_row(a_row), .rd_col(a_col), .rd_data(rnd_rdata),
    .line_row(line_row), .line(line)
  );

  dpv_serial #(.ROW_W(ROW_W), .COL_W(COL_W), .NIB_W(NIB_W), .LANES(LANES)) u_ser (
    .clk(clk), .rst_n(rst_ni), .load_en(x_load), .load_row(x_row),
    .set_en(x_set), .set_ptr(x_ptr), .line_in(line), .next_row(next_row),
    .ser_valid(ser_valid), .ser_data(ser_data)
  );

  assign abus_ph = ph;
endmodule

// File: rtl/dpv_chk.sv
module dpv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ph,
  input logic       rnd_req,
  input logic       rnd_ready,
  input logic       rnd_rvalid,
  input logic       ser_start,
  input logic       ser_valid
);
  AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd1) |=> (ph == 3'd2)); // R2
  AST_COL_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd2) |=> (ph == 3'd3)); // R2
  AST_ACCEPT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_req && rnd_ready) |=> (ph == 3'd1)); // R3
  AST_RVALID_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_rvalid |-> (ph == 3'd3)); // R4
  AST_XROW_THEN_XPTR: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd4) |=> (ph == 3'd5)); // R5
  AST_QUIET_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == 3'd4) || (ph == 3'd5)) |-> !ser_valid); // R5
  AST_STREAM_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd5) |=> (ser_valid || (ph == 3'd4))); // R5
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_start && rnd_req) |-> !rnd_ready); // R8
endmodule

bind dpvram_ctrl dpv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(abus_ph), .rnd_req(rnd_req), .rnd_ready(rnd_ready),
  .rnd_rvalid(rnd_rvalid), .ser_start(ser_start), .ser_valid(ser_valid)
);

// File: tb/sim_dpvram_ctrl.sv
module sim_dpvram_ctrl;
  localparam int CLK_P = 10;
  localparam int ROW_W = 3;
  localparam int COL_W = 8;
  localparam int ROWS  = 1 << ROW_W;
  localparam int NCOL  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n;
  logic rnd_req, rnd_we, rnd_ready, rnd_rvalid, ser_start, ser_valid;
  logic [ROW_W-1:0] rnd_row, ser_row;
  logic [COL_W-1:0] rnd_col, ser_ptr;
  logic [7:0] rnd_wdata, rnd_rdata, ser_data, abus;
  logic [2:0] abus_ph;

  always #(CLK_P/2) clk = ~clk;

  dpvram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rnd_req(rnd_req), .rnd_we(rnd_we), .rnd_row(rnd_row),
    .rnd_col(rnd_col), .rnd_wdata(rnd_wdata), .rnd_ready(rnd_ready),
    .rnd_rvalid(rnd_rvalid), .rnd_rdata(rnd_rdata), .ser_start(ser_start),
    .ser_row(ser_row), .ser_ptr(ser_ptr), .ser_valid(ser_valid), .ser_data(ser_data),
    .abus(abus), .abus_ph(abus_ph)
  );

  int ncmp = 0;
  int nbad = 0;
  string sec = "R1";
  bit model_on = 1'b0;

  // reference model: memory contents, pending bus phases, stream state
  typedef struct packed {int ph; int bus; int we; int row; int col; int d;} item_t;
  item_t q[$];
  int mem [ROWS][NCOL];
  int sbuf [NCOL];
  bit act = 1'b0;
  int sptr = 0;
  int crow = 0;
  bit sp = 1'b0;
  int sp_row = 0;
  int sp_ptr = 0;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    ncmp++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t", tag, sec, what, got, exp, $time);
    end
  endtask

  function automatic bit m_slot_rnd();
    return (q.size() == 0) || (q.size() == 1 && q[0].ph == 3);
  endfunction

  function automatic bit m_slot_x();
    return m_slot_rnd() || (q.size() == 1 && q[0].ph == 5);
  endfunction

  function automatic bit m_ready();
    return m_slot_rnd() && !(ser_start || sp);
  endfunction

  function automatic item_t mk(int ph, int bus, int we, int row, int col, int d);
    item_t it;
    it.ph = ph; it.bus = bus; it.we = we; it.row = row; it.col = col; it.d = d;
    return it;
  endfunction

  always @(posedge clk) begin
    if (model_on) begin : mdl
      item_t it;
      bit sn, gx, acc;
      int sr, spt;
      sn  = ser_start || sp;
      sr  = ser_start ? int'(ser_row) : sp_row;
      spt = ser_start ? int'(ser_ptr) : sp_ptr;
      gx  = m_slot_x() && sn;
      acc = rnd_req && m_ready();
      if (act) begin
        if (sptr == NCOL-1) begin
          sptr = 0;
          crow = (crow + 1) % ROWS;
          for (int c = 0; c < NCOL; c++) sbuf[c] = mem[crow][c];
        end else sptr++;
      end
      if (q.size() != 0) begin
        it = q.pop_front();
        if (it.ph == 4) begin
          for (int c = 0; c < NCOL; c++) sbuf[c] = mem[it.row][c];
          crow = it.row;
          act = 1'b0;
        end else if (it.ph == 5) begin
          sptr = it.bus;
          act = 1'b1;
        end else if (it.ph == 3 && it.we != 0) begin
          mem[it.row][it.col] = it.d;
        end
      end
      if (gx) begin
        q.push_back(mk(4, sr, 0, sr, 0, 0));
        q.push_back(mk(5, spt, 0, 0, 0, 0));
        sp = 1'b0;
      end else if (ser_start) begin
        sp = 1'b1;
        sp_row = int'(ser_row);
        sp_ptr = int'(ser_ptr);
      end
      if (acc) begin
        q.push_back(mk(1, int'(rnd_row), 0, 0, 0, 0));
        q.push_back(mk(2, int'(rnd_col), 0, 0, 0, 0));
        q.push_back(mk(3, rnd_we ? int'(rnd_wdata) : 0, int'(rnd_we),
                       int'(rnd_row), int'(rnd_col), int'(rnd_wdata)));
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin : cmp
      int fph, fbus;
      bit ev, es;
      fph  = (q.size() != 0) ? q[0].ph : 0;
      fbus = (q.size() != 0) ? q[0].bus : 0;
      chk("R2", "bus phase", int'(abus_ph), fph);
      chk("R2", "bus value", int'(abus), fbus);
      chk("R3", "ready", int'(rnd_ready), int'(m_ready()));
      ev = (fph == 3) && (q[0].we == 0);
      chk("R4", "rvalid", int'(rnd_rvalid), int'(ev));
      if (ev && mem[q[0].row][q[0].col] >= 0)
        chk("R4", "rdata", int'(rnd_rdata), mem[q[0].row][q[0].col]);
      es = act && fph != 4 && fph != 5;
      chk("R5", "ser_valid", int'(ser_valid), int'(es));
      if (es && sbuf[sptr] >= 0) chk("R6", "ser_data", int'(ser_data), sbuf[sptr]);
    end
  end

  task automatic rnd_wait();
    bit ok;
    forever begin
      @(negedge clk);
      ok = rnd_ready;
      @(posedge clk);
      #1;
      if (ok) break;
    end
    rnd_req = 1'b0;
  endtask

  task automatic rnd_set(input bit we, input int row, input int col, input int d);
    rnd_req   = 1'b1;
    rnd_we    = we;
    rnd_row   = ROW_W'(row);
    rnd_col   = COL_W'(col);
    rnd_wdata = 8'(d);
  endtask

  task automatic rnd_op(input bit we, input int row, input int col, input int d);
    rnd_set(we, row, col, d);
    rnd_wait();
  endtask

  task automatic start(input int row, input int ptr);
    ser_start = 1'b1;
    ser_row   = ROW_W'(row);
    ser_ptr   = COL_W'(ptr);
    @(posedge clk);
    #1;
    ser_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  function automatic int pat(input int r, input int c);
    return (r * 37 + c * 11 + 5) & 255;
  endfunction

  initial begin
    #(CLK_P * 150000);
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < NCOL; c++) mem[r][c] = -1;
    for (int c = 0; c < NCOL; c++) sbuf[c] = -1;
    rst_n = 1'b0;
    rnd_req = 1'b0; rnd_we = 1'b0; rnd_row = '0; rnd_col = '0; rnd_wdata = '0;
    ser_start = 1'b0; ser_row = '0; ser_ptr = '0;
    @(posedge clk);
    @(negedge clk);
    sec = "R1";
    chk("R1", "reset phase", int'(abus_ph), 0);
    chk("R1", "reset bus", int'(abus), 0);
    chk("R1", "reset rvalid", int'(rnd_rvalid), 0);
    chk("R1", "reset ser_valid", int'(ser_valid), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    chk("R1", "ready after reset", int'(rnd_ready), 1);
    model_on = 1'b1;

    sec = "R3";
    for (int c = 0; c < NCOL; c++) rnd_op(1'b1, 0, c, pat(0, c));
    for (int c = 0; c < NCOL; c++) rnd_op(1'b1, 1, c, pat(1, c));
    for (int c = 248; c < NCOL; c++) rnd_op(1'b1, 7, c, pat(7, c));

    sec = "R4";
    rnd_op(1'b0, 0, 0, 0);
    rnd_op(1'b0, 1, 255, 0);
    rnd_op(1'b0, 7, 250, 0);
    rnd_op(1'b1, 0, 128, 8'h5a);
    rnd_op(1'b0, 0, 128, 0);
    idle(3);

    sec = "R7";
    start(0, 250);
    idle(4);
    sec = "R6";
    rnd_op(1'b1, 1, 10, 8'ha5);
    rnd_op(1'b0, 1, 10, 0);
    idle(12);

    sec = "R8";
    rnd_set(1'b0, 0, 5, 0);
    ser_start = 1'b1; ser_row = ROW_W'(1); ser_ptr = COL_W'(3);
    @(posedge clk);
    #1 ser_start = 1'b0;
    rnd_wait();
    idle(6);

    sec = "R9";
    rnd_op(1'b1, 0, 7, 8'h3c);
    start(7, 254);
    idle(12);

    sec = "R10";
    start(1, 100);
    idle(6);
    start(0, 1);
    start(1, 2);
    idle(8);
    rnd_op(1'b0, 0, 7, 0);
    idle(6);

    model_on = 1'b0;
    finish_up();
  end
endmodule